// File: doc/BRIEF.md
# Flat-Panel Power Sequencer

This block brings a flat panel up and down by switching four enable controls one at a time, in a fixed order: logic supply, data signals, backlight bias and panel-on. Powering down walks the same four controls in the opposite order. The host gives a one-cycle request with a target state (on or off). The block applies the first change on the clock edge that samples the request. It then waits a set number of vertical-sync periods before each further change, and also after the last one, before it reports the sequence as finished.

One vertical-sync period is counted as the vsync-active input first being seen clear and then being seen set again. The input is sampled once per clock, and each sample is one poll. Either half of a period gives up after a bounded number of polls, so a stalled sync source slows the sequence but cannot hang it. A two-bit status output tells whether the panel is off, on, powering up or powering down.

A request that arrives while a sequence is running is not acted on at once. If the most recent such request asks for the opposite state, the reversal starts as soon as the running sequence has finished. A request for the state the panel is already in is ignored.

Top module: `panel_power_seq`

## Requirements
- R1: Power-up sets the controls in the order supplyEn, signalEn, biasEn, panelEn, setting one control per step.
- R2: Power-down clears the controls in the order panelEn, biasEn, signalEn, supplyEn, clearing one control per step.
- R3: After every change, including the last one of a sequence, the block waits WAIT_FRAMES (4) vsync periods before the next change or before completion. A period ends on the edge that first samples vsyncActive high after it has been sampled low, so the next event falls on the edge of the fourth such rise.
- R4: Each step changes exactly one of the four controls. The other three hold their values.
- R5: Each half of a vsync period ends after POLL_LIMIT polls (one per clock) even if vsyncActive never takes the awaited level. With vsync stuck high or stuck low, changes are therefore 4*(POLL_LIMIT+1) cycles apart.
- R6: While a sequence runs, the latest request received decides what follows. If it asks for the opposite state, the reverse sequence starts at the completion edge, after all four steps of the current sequence. A same-direction request cancels an earlier opposite one.
- R7: A request for the state the panel is already in (while idle) changes no output and causes no waiting. The status stays as it was.
- R8: Reset (rstN low, asynchronous) clears all four controls and sets the status to off.
- R9: The status encoding is 2'b00 off, 2'b01 on, 2'b10 powering up, 2'b11 powering down. The first control changes, and the status turns busy, on the clock edge that samples an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | One-cycle request strobe |
| reqOn | input | 1 | Requested state: 1 on, 0 off |
| vsyncActive | input | 1 | Vertical-sync active status, sampled every clock |
| supplyEn | output | 1 | Panel logic supply enable |
| signalEn | output | 1 | Panel data signal enable |
| biasEn | output | 1 | Backlight bias enable |
| panelEn | output | 1 | Panel-on enable |
| status | output | 2 | 00 off, 01 on, 10 powering up, 11 powering down |

## Verification
An accepted request shows its first control change and the busy status on the very next edge. The bench samples these outputs at the following falling edge. Each later change, and the return to an idle status, is due on the edge where vsyncActive is sampled high for the fourth time since the previous change. The bench drives vsync itself and counts the rises per interval and whether the change landed on a rise. With the sync source stalled, it measures the gap in cycles against 4*(POLL_LIMIT+1) instead.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;
  localparam int CTRL_COUNT = 4;
  localparam int CTRL_IDX_W = $clog2(CTRL_COUNT);

  typedef enum logic [1:0] {
    STAT_OFF     = 2'b00,
    STAT_ON      = 2'b01,
    STAT_RISING  = 2'b10,
    STAT_FALLING = 2'b11
  } panel_status_e;

  // One step strobe from control to datapath: flip one control and start a wait.
  typedef struct packed {
    logic                  go;
    logic                  dirUp;
    logic [CTRL_IDX_W-1:0] idx;
  } step_cmd_t;
endpackage

// File: rtl/panel_seq_datapath.sv
module panel_seq_datapath
  import panel_seq_pkg::*;
#(
  parameter int WAIT_FRAMES = 4,
  parameter int POLL_LIMIT  = 10000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  step_cmd_t             stepCmd,
  input  logic                  vsyncActive,
  output logic [CTRL_COUNT-1:0] enables,
  output logic                  waitBusy,
  output logic                  waitDone
);
  localparam int POLL_W  = $clog2(POLL_LIMIT + 1);
  localparam int FRAME_W = $clog2(WAIT_FRAMES + 1);
  localparam logic [POLL_W-1:0]     POLL_LAST  = POLL_W'(POLL_LIMIT - 1);
  localparam logic [FRAME_W-1:0]    FRAME_LAST = FRAME_W'(WAIT_FRAMES - 1);
  localparam logic [CTRL_IDX_W-1:0] IDX_TOP    = CTRL_IDX_W'(CTRL_COUNT - 1);

  logic [CTRL_COUNT-1:0] enQ;
  logic [CTRL_IDX_W-1:0] bitSel;
  logic                  waiting;
  logic                  phaseSet;   // 0: awaiting vsync clear, 1: awaiting vsync set
  logic [POLL_W-1:0]     pollCnt;
  logic [FRAME_W-1:0]    frameCnt;
  logic                  pollHit, pollExpire, phaseEnd, frameEnd;

  // Down sequences walk the controls from the top index downwards.
  assign bitSel = stepCmd.dirUp ? stepCmd.idx : IDX_TOP - stepCmd.idx;

  for (genvar i = 0; i < CTRL_COUNT; i++) begin : g_ctrl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ[i] <= 1'b0;
      end else if (stepCmd.go && bitSel == CTRL_IDX_W'(i)) begin
        enQ[i] <= stepCmd.dirUp;
      end
    end
  end

  assign pollHit    = phaseSet ? vsyncActive : ~vsyncActive;
  assign pollExpire = (pollCnt == POLL_LAST);
  assign phaseEnd   = waiting && (pollHit || pollExpire);
  assign frameEnd   = phaseEnd && phaseSet;
  assign waitDone   = frameEnd && (frameCnt == FRAME_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waiting  <= 1'b0;
      phaseSet <= 1'b0;
      pollCnt  <= '0;
      frameCnt <= '0;
    end else if (stepCmd.go) begin
      waiting  <= 1'b1;
      phaseSet <= 1'b0;
      pollCnt  <= '0;
      frameCnt <= '0;
    end else if (waiting) begin
      if (phaseEnd) begin
        pollCnt  <= '0;
        phaseSet <= ~phaseSet;
        if (frameEnd) begin
          if (frameCnt == FRAME_LAST) waiting <= 1'b0;
          else                        frameCnt <= frameCnt + 1'b1;
        end
      end else begin
        pollCnt <= pollCnt + 1'b1;
      end
    end
  end

  assign enables  = enQ;
  assign waitBusy = waiting;

  // R4: no edge ever flips more than one control
  assert_single_change_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(enQ ^ $past(enQ)) <= 1);

  // R4: controls move only on a step strobe
  assert_move_on_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    !stepCmd.go |=> $stable(enQ));

  // R1 / R2: the enable set is always a prefix starting at the supply control
  assert_prefix_order_R1: assert property (@(posedge clk) disable iff (!rstN)
    (enQ & CTRL_COUNT'(enQ + 1'b1)) == '0);

  // R5: a polling phase never runs past its poll budget
  assert_poll_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    waiting |-> pollCnt <= POLL_LAST);
endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
  import panel_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqOn,
  input  logic      waitDone,
  output step_cmd_t stepCmd,
  output logic [1:0] status
);
  localparam logic [CTRL_IDX_W-1:0] IDX_LAST = CTRL_IDX_W'(CTRL_COUNT - 1);

  logic                  running;
  logic                  dirUp;
  logic                  isOn;
  logic                  pendFlip;
  logic [CTRL_IDX_W-1:0] stepIdx;
  logic                  startFresh, lastStep, seqDone, flipAfter, advance;
  panel_status_e         statusE;

  assign startFresh = !running && reqValid && (reqOn != isOn);
  assign lastStep   = (stepIdx == IDX_LAST);
  assign seqDone    = running && waitDone && lastStep;
  assign advance    = running && waitDone && !lastStep;
  // The latest request wins; one arriving on the completion edge counts too.
  assign flipAfter  = seqDone && (reqValid ? (reqOn != dirUp) : pendFlip);

  always_comb begin
    stepCmd.go    = startFresh || advance || flipAfter;
    stepCmd.dirUp = startFresh ? reqOn : (flipAfter ? ~dirUp : dirUp);
    stepCmd.idx   = advance ? stepIdx + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      dirUp    <= 1'b0;
      isOn     <= 1'b0;
      pendFlip <= 1'b0;
      stepIdx  <= '0;
    end else if (startFresh) begin
      running  <= 1'b1;
      dirUp    <= reqOn;
      stepIdx  <= '0;
      pendFlip <= 1'b0;
    end else if (running) begin
      if (seqDone) begin
        isOn     <= dirUp;
        pendFlip <= 1'b0;
        stepIdx  <= '0;
        if (flipAfter) dirUp   <= ~dirUp;
        else           running <= 1'b0;
      end else begin
        if (advance)  stepIdx  <= stepIdx + 1'b1;
        if (reqValid) pendFlip <= (reqOn != dirUp);
      end
    end
  end

  always_comb begin
    if (running) statusE = dirUp ? STAT_RISING : STAT_FALLING;
    else         statusE = isOn ? STAT_ON : STAT_OFF;
  end
  assign status = statusE;

  // R6: direction of a running sequence changes only at its completion edge
  assert_no_early_reverse_R6: assert property (@(posedge clk) disable iff (!rstN)
    (running && !(waitDone && lastStep)) |=> (dirUp == $past(dirUp)));

  // R7: while idle, a request matching the current state issues no step
  assert_same_state_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!running && reqValid && reqOn == isOn) |-> !stepCmd.go);
endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
  import panel_seq_pkg::*;
#(
  parameter int WAIT_FRAMES = 4,
  parameter int POLL_LIMIT  = 10000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqOn,
  input  logic       vsyncActive,
  output logic       supplyEn,
  output logic       signalEn,
  output logic       biasEn,
  output logic       panelEn,
  output logic [1:0] status
);
  step_cmd_t             stepCmd;
  logic [CTRL_COUNT-1:0] enables;
  logic                  waitBusy;
  logic                  waitDone;

  panel_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOn    (reqOn),
    .waitDone (waitDone),
    .stepCmd  (stepCmd),
    .status   (status)
  );

  panel_seq_datapath #(
    .WAIT_FRAMES (WAIT_FRAMES),
    .POLL_LIMIT  (POLL_LIMIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stepCmd     (stepCmd),
    .vsyncActive (vsyncActive),
    .enables     (enables),
    .waitBusy    (waitBusy),
    .waitDone    (waitDone)
  );

  assign supplyEn = enables[0];
  assign signalEn = enables[1];
  assign biasEn   = enables[2];
  assign panelEn  = enables[3];

  // R3: a new step may only start once the previous wait has finished
  assert_step_after_wait_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stepCmd.go && waitBusy) |-> waitDone);

  // R9: idle status codes agree with the controls actually driven
  assert_idle_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'b00 |-> enables == '0) and (status == 2'b01 |-> enables == '1));
endmodule

// File: tb/panel_power_seq_test.sv
`timescale 1ns/1ps
module panel_power_seq_test;
  localparam int POLL_LIM = 16;
  localparam int FRAMES   = 4;
  localparam int STALL_GAP = FRAMES * (POLL_LIM + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqOn = 1'b0;
  logic vsync = 1'b0;
  logic supplyEn, signalEn, biasEn, panelEn;
  logic [1:0] status;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  panel_power_seq #(.WAIT_FRAMES(FRAMES), .POLL_LIMIT(POLL_LIM)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOn(reqOn),
    .vsyncActive(vsync), .supplyEn(supplyEn), .signalEn(signalEn),
    .biasEn(biasEn), .panelEn(panelEn), .status(status)
  );

  // vector: {reqOn, expected enables[3:0], expected status[1:0], sequence expected}
  localparam logic [7:0] VEC [6] = '{
    8'b1_1111_01_1, 8'b1_1111_01_0, 8'b0_0000_00_1,
    8'b0_0000_00_0, 8'b1_1111_01_1, 8'b0_0000_00_1
  };

  // monitor log
  int vsMode = 0;          // 0 periodic, 1 stuck high, 2 stuck low
  int vsPhase = 0;
  bit prevVs = 0;
  logic [3:0] prevEn = '0;
  logic [1:0] prevStat = '0;
  int nChg = 0;
  int chgDiff [16];
  int chgVal [16];
  int chgRises [16];
  bit chgOnRise [16];
  int chgGap [16];
  int risesSince = 0;
  int cycle = 0;
  int lastChgCycle = 0;
  int endRises = 0;
  bit endOnRise = 0;
  int endGap = 0;

  function automatic logic [3:0] enNow();
    return {panelEn, biasEn, signalEn, supplyEn};
  endfunction

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor and vsync driver, both at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      begin
        bit rise;
        logic [3:0] en;
        rise = vsync && !prevVs;
        prevVs = vsync;
        if (rise) risesSince++;
        en = enNow();
        if (en != prevEn) begin
          if (nChg < 16) begin
            chgDiff[nChg]   = int'(en ^ prevEn);
            chgVal[nChg]    = int'(en);
            chgRises[nChg]  = risesSince;
            chgOnRise[nChg] = rise;
            chgGap[nChg]    = cycle - lastChgCycle;
          end
          nChg++;
          risesSince = 0;
          lastChgCycle = cycle;
        end
        if (prevStat[1] && !status[1]) begin
          endRises  = risesSince;
          endOnRise = rise;
          endGap    = cycle - lastChgCycle;
        end
        prevStat = status;
        prevEn = en;
        cycle++;
        vsPhase = (vsPhase + 1) % 12;
        case (vsMode)
          1: vsync = 1'b1;
          2: vsync = 1'b0;
          default: vsync = (vsPhase < 3);
        endcase
      end
    end
  end

  task automatic sendReq(input bit on);
    @(negedge clk);
    reqValid = 1'b1;
    reqOn = on;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (status[1] && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (status[1]) chkEq("R3 sequence did not finish", 1, 0);
  endtask

  task automatic waitChanges(input int target);
    int n = 0;
    while (nChg < target && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (nChg < target) chkEq("R3 change count reached", nChg, target);
  endtask

  // check four logged changes starting at base for order and vsync spacing
  task automatic verifySeq(input bit up, input int base, input bit timed);
    for (int k = 0; k < 4; k++) begin
      int b = up ? k : 3 - k;
      chkEq(up ? "R1 up order bit" : "R2 down order bit", chgDiff[base + k], 1 << b);
      if (timed && k > 0) begin
        chkEq("R3 vsync rises between steps", chgRises[base + k], FRAMES);
        chkEq("R3 step lands on vsync rise", int'(chgOnRise[base + k]), 1);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chkEq("R8 enables at reset", int'(enNow()), 0);
    chkEq("R8 status at reset", int'(status), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chkEq("R8 enables after reset release", int'(enNow()), 0);

    // table-driven sequences with periodic vsync
    for (int v = 0; v < 6; v++) begin
      logic [3:0] enBefore;
      logic [1:0] statBefore;
      enBefore = enNow();
      statBefore = status;
      nChg = 0;
      sendReq(VEC[v][7]);
      if (VEC[v][0]) begin
        chkEq("R9 busy status on accept", int'(status), VEC[v][7] ? 2 : 3);
        chkEq("R9 first step on accept edge", nChg, 1);
        waitIdle();
        chkEq("R4 change count per sequence", nChg, 4);
        verifySeq(VEC[v][7], 0, 1);
        chkEq("R3 rises before completion", endRises, FRAMES);
        chkEq("R3 completion on vsync rise", int'(endOnRise), 1);
      end else begin
        chkEq("R7 status unchanged", int'(status), int'(statBefore));
        repeat (60) @(negedge clk);
        chkEq("R7 no output change", int'(enNow()), int'(enBefore));
        chkEq("R7 no change logged", nChg, 0);
      end
      chkEq("R9 final enables", int'(enNow()), int'(VEC[v][6:3]));
      chkEq("R9 final status", int'(status), int'(VEC[v][2:1]));
    end

    // R5: vsync stuck high, then stuck low
    vsMode = 1;
    nChg = 0;
    sendReq(1'b1);
    waitIdle();
    verifySeq(1'b1, 0, 1'b0);
    for (int k = 1; k < 4; k++) chkEq("R5 gap with vsync stuck high", chgGap[k], STALL_GAP);
    chkEq("R5 completion gap stuck high", endGap, STALL_GAP);
    vsMode = 2;
    nChg = 0;
    sendReq(1'b0);
    waitIdle();
    verifySeq(1'b0, 0, 1'b0);
    for (int k = 1; k < 4; k++) chkEq("R5 gap with vsync stuck low", chgGap[k], STALL_GAP);
    chkEq("R5 completion gap stuck low", endGap, STALL_GAP);
    chkEq("R5 off after stalled sequence", int'(status), 0);
    vsMode = 0;

    // R6: opposite request mid-sequence is held until completion
    nChg = 0;
    sendReq(1'b1);
    waitChanges(2);
    sendReq(1'b0);
    chkEq("R6 still powering up after opposite request", int'(status), 2);
    waitChanges(5);
    chkEq("R6 up sequence fully completed", chgVal[3], 15);
    chkEq("R6 reversal shows falling status", int'(status), 3);
    waitIdle();
    chkEq("R6 total changes", nChg, 8);
    verifySeq(1'b1, 0, 1'b1);
    verifySeq(1'b0, 4, 1'b1);
    chkEq("R6 reversal waited after last up step", chgRises[4], FRAMES);
    chkEq("R6 final enables off", int'(enNow()), 0);

    // R6: a same-direction request cancels an earlier opposite one
    nChg = 0;
    sendReq(1'b1);
    waitChanges(1);
    sendReq(1'b0);
    sendReq(1'b1);
    waitIdle();
    repeat (60) @(negedge clk);
    chkEq("R6 cancelled reversal change count", nChg, 4);
    chkEq("R6 cancelled reversal stays on", int'(enNow()), 15);
    chkEq("R6 cancelled reversal status", int'(status), 1);

    // R8: reset in the middle of a power-down
    nChg = 0;
    sendReq(1'b0);
    waitChanges(2);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chkEq("R8 mid-sequence reset enables", int'(enNow()), 0);
    chkEq("R8 mid-sequence reset status", int'(status), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    chkEq("R8 stays off after reset", int'(enNow()), 0);

    summary();
  end
endmodule